// File: doc/BRIEF.md
# Floating-Point Register Store Sequencer

This block takes one 32-bit floating-point coprocessor store instruction, together with the current value of its integer base register. It then turns the instruction into a stream of word writes on a valid/ready memory port. The source words come from a 32-word register file through a combinational read port. A double-precision register Dn occupies words 2n (low half) and 2n+1 (high half), and a single-precision register Sn is word n. Five store forms are recognised: one single-precision word, one double-precision register, a run of single-precision registers, a run of double-precision registers, and a format-agnostic run of double-precision registers that is marked by an odd word offset.

An external condition-pass input decides whether the instruction executes. Before any write is issued, the register lists are checked for being empty or for running past the top of the file. A rejected list issues no writes and raises an unpredictable flag alongside the done pulse. For multiple stores that request it, the updated base value is reported with done. Once the first cycle is over, the sequencer is busy until done, and it ignores any start it receives in that time.

The FSM has three states. `ST_IDLE` waits for start. `ST_XFER` offers one word per cycle. `ST_FIN` pulses done for one cycle. There are four transitions. `T_LAUNCH` (IDLE to XFER) fires on start when the condition passes and the list is valid. `T_SKIP` (IDLE to FIN) fires on start when the condition fails or the instruction is rejected. `T_LAST` (XFER to FIN) fires when the last word is accepted. `T_RETIRE` (FIN to IDLE) fires unconditionally.

Top module: `fpst_seq`

## Requirements
- R1: Single-precision single store (P=1 and W=0 in bits 24 and 21, selector 1010 in bits 11:8) writes one word. The word is register-file word {bits 15:12, bit 22}, and it goes to base + offset*4 when U (bit 23) is 1, or to base - offset*4 when U is 0. Offset is bits 7:0.
- R2: Double-precision single store (P=1, W=0, selector 1011) writes two words. Word 2d goes to the computed address and word 2d+1 goes to the address + 4, where d is bits 15:12.
- R3: Single-precision multiple store (selector 1010, not P=1/W=0) writes `offset` words starting at word {bits 15:12, bit 22}. The register index rises by one per word and the address rises by 4 per word. The first address is the base when U=1, or the base - offset*4 when U=0.
- R4: Double-precision multiple store (selector 1011, even offset) writes offset/2 registers starting at D(d), each as its low word and then its high word, at ascending addresses.
- R5: Format-agnostic multiple store (selector 1011, odd offset) writes offset-1 words starting at word 2d, with the same address rule as R3.
- R6: When a multiple store with W=1 executes, wb_en is high in the done cycle and wb_data is base + offset*4 (U=1) or base - offset*4 (U=0). In all other cases wb_en stays low.
- R7: The instruction is rejected with no writes and with unpred high in the done cycle in any of these cases: bits 27:25 are not 110; bit 20 is 1; the selector is neither 1010 nor 1011; a multiple list has offset 0; single-precision first + offset > 32; double-precision d + offset/2 > 16; format-agnostic offset is 1 or d + (offset-1)/2 > 16.
- R8: With cond_pass low at start, no write is issued and unpred and wb_en stay low. Done rises in the cycle after start is sampled, which is also the timing for R7 rejections.
- R9: While mem_valid is high and mem_ready is low, mem_addr and the register index are held. Done is a single-cycle pulse in the cycle after the last accepted write.
- R10: A start received while busy is ignored. Busy drops in the cycle after done.
- R11: After reset, busy, mem_valid, done, unpred and wb_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction present; sampled only when idle |
| insn | input | 32 | Store instruction word |
| base | input | 32 | Current value of the base register |
| cond_pass | input | 1 | Condition result; low cancels the instruction |
| busy | output | 1 | Sequencer occupied |
| rf_addr | output | 5 | Register-file word index being read |
| rf_rdata | input | 32 | Register-file word at rf_addr |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Write request accepted |
| mem_addr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| unpred | output | 1 | Rejected instruction, valid with done |
| wb_en | output | 1 | Base writeback request, valid with done |
| wb_data | output | 32 | Updated base value |

## Verification
Two events can land in the same cycle: a new start request, and the done pulse that retires the previous instruction (or a write that is still stalled). The bench drives start with random unrelated instruction words throughout busy periods, including the done cycle, while mem_ready is randomly withheld. Any captured start would show up as extra writes, a missing busy drop, or a wrong word stream against the independently computed expected list. The position of done relative to the last accepted write is also checked cycle by cycle.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
    localparam int INSN_W   = 32;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int RF_WORDS = 32;
    localparam int RF_IDX_W = $clog2(RF_WORDS);
    localparam int OFF_W    = 8;
    localparam int CNT_W    = OFF_W;
    localparam int SUM_W    = OFF_W + 2;
    localparam int WORD_SH  = 2;
    localparam int BYTES_W  = 1 << WORD_SH;

    // instruction field positions (decoded by neighbours, so fixed)
    localparam int BIT_P  = 24;
    localparam int BIT_U  = 23;
    localparam int BIT_D  = 22;
    localparam int BIT_W  = 21;
    localparam int BIT_L  = 20;

    localparam logic [3:0] SEL_SGL = 4'b1010;
    localparam logic [3:0] SEL_DBL = 4'b1011;
    localparam logic [2:0] CLS_CP  = 3'b110;

    typedef enum logic [2:0] {
        KIND_ONE_S,
        KIND_ONE_D,
        KIND_MANY_S,
        KIND_MANY_D,
        KIND_MANY_X
    } kind_e;

    typedef struct packed {
        kind_e                kind;
        logic                 bad;
        logic [RF_IDX_W-1:0]  first;
        logic [CNT_W-1:0]     nwords;
        logic [ADDR_W-1:0]    addr0;
        logic                 wb_req;
        logic [ADDR_W-1:0]    wb_val;
    } plan_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_FIN
    } state_e;
endpackage

// File: rtl/fpst_decode.sv
module fpst_decode
    import fpst_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic [ADDR_W-1:0] base,
    output plan_t             plan
);
    logic                p_bit, u_bit, d_bit, w_bit;
    logic [3:0]          fd;
    logic [3:0]          sel;
    logic [OFF_W-1:0]    off;
    logic [ADDR_W-1:0]   span, up_val, dn_val;
    logic [RF_IDX_W-1:0] s_reg, d_word;
    logic [SUM_W-1:0]    s_end, d_end;
    logic                enc_ok, is_sgl, is_dbl, one_reg;

    assign p_bit  = insn[BIT_P];
    assign u_bit  = insn[BIT_U];
    assign d_bit  = insn[BIT_D];
    assign w_bit  = insn[BIT_W];
    assign fd     = insn[15:12];
    assign sel    = insn[11:8];
    assign off    = insn[OFF_W-1:0];

    assign span   = ADDR_W'(off) << WORD_SH;
    assign up_val = base + span;
    assign dn_val = base - span;

    assign s_reg  = {fd, d_bit};
    assign d_word = {fd, 1'b0};
    assign s_end  = SUM_W'(s_reg) + SUM_W'(off);
    // floor(off/2) also equals (off-1)/2 for the odd-offset form
    assign d_end  = SUM_W'(fd) + SUM_W'(off >> 1);

    assign is_sgl  = (sel == SEL_SGL);
    assign is_dbl  = (sel == SEL_DBL);
    assign enc_ok  = (insn[27:25] == CLS_CP) && !insn[BIT_L] && (is_sgl || is_dbl);
    assign one_reg = p_bit && !w_bit;

    always_comb begin
        plan        = '0;
        plan.kind   = KIND_ONE_S;
        if (one_reg) begin
            plan.addr0  = u_bit ? up_val : dn_val;
            plan.wb_req = 1'b0;
            plan.wb_val = base;
            if (is_dbl) begin
                plan.kind   = KIND_ONE_D;
                plan.first  = d_word;
                plan.nwords = CNT_W'(2);
            end else begin
                plan.kind   = KIND_ONE_S;
                plan.first  = s_reg;
                plan.nwords = CNT_W'(1);
            end
            plan.bad = !enc_ok;
        end else begin
            plan.addr0  = u_bit ? base : dn_val;
            plan.wb_req = w_bit;
            plan.wb_val = u_bit ? up_val : dn_val;
            if (is_sgl) begin
                plan.kind   = KIND_MANY_S;
                plan.first  = s_reg;
                plan.nwords = off;
                plan.bad    = (off == '0) || (s_end > SUM_W'(RF_WORDS));
            end else if (off[0]) begin
                plan.kind   = KIND_MANY_X;
                plan.first  = d_word;
                plan.nwords = off - CNT_W'(1);
                plan.bad    = (off == OFF_W'(1)) || (d_end > SUM_W'(RF_WORDS / 2));
            end else begin
                plan.kind   = KIND_MANY_D;
                plan.first  = d_word;
                plan.nwords = off;
                plan.bad    = (off == '0) || (d_end > SUM_W'(RF_WORDS / 2));
            end
            plan.bad = plan.bad || !enc_ok;
        end
    end
endmodule

// File: rtl/fpst_addr_walk.sv
module fpst_addr_walk
    import fpst_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   addr0,
    input  logic [RF_IDX_W-1:0] first,
    input  logic                step,
    output logic [ADDR_W-1:0]   cur_addr,
    output logic [RF_IDX_W-1:0] rf_idx
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rf_idx   <= '0;
        end else if (load) begin
            cur_addr <= addr0;
            rf_idx   <= first;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_W'(BYTES_W);
            rf_idx   <= rf_idx + RF_IDX_W'(1);
        end
    end

    AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step)); // R10
endmodule

// File: rtl/fpst_ctrl.sv
module fpst_ctrl
    import fpst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cond_pass,
    input  plan_t             plan,
    input  logic              mem_ready,
    output logic              load,
    output logic              step,
    output logic              busy,
    output logic              mem_valid,
    output logic              done,
    output logic              unpred,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_data
);
    state_e            state, state_nx;
    logic [CNT_W-1:0]  remain;
    logic              unpred_q, wb_q;
    logic [ADDR_W-1:0] wb_val_q;
    logic              go;

    assign go = cond_pass && !plan.bad;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = go ? ST_XFER : ST_FIN;  // T_LAUNCH / T_SKIP
            ST_XFER: if (mem_ready && remain == CNT_W'(1)) state_nx = ST_FIN; // T_LAST
            ST_FIN:  state_nx = ST_IDLE;                              // T_RETIRE
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // per-instruction bookkeeping captured at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain   <= '0;
            unpred_q <= 1'b0;
            wb_q     <= 1'b0;
            wb_val_q <= '0;
        end else if (load) begin
            remain   <= plan.nwords;
            unpred_q <= cond_pass && plan.bad;
            wb_q     <= go && plan.wb_req;
            wb_val_q <= plan.wb_val;
        end else if (step) begin
            remain   <= remain - CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        load      = 1'b0;
        mem_valid = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: load      = start;
            ST_XFER: mem_valid = 1'b1;
            ST_FIN:  done      = 1'b1;
            default: ;
        endcase
        step    = mem_valid && mem_ready;
        busy    = (state != ST_IDLE);
        unpred  = done && unpred_q;
        wb_en   = done && wb_q;
        wb_data = wb_val_q;
    end

    AST_REMAIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> remain != '0); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R10
    AST_WB_NOT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        unpred |-> !wb_en); // R6
endmodule

// File: rtl/fpst_seq.sv
module fpst_seq
    import fpst_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [INSN_W-1:0]   insn,
    input  logic [ADDR_W-1:0]   base,
    input  logic                cond_pass,
    output logic                busy,
    output logic [RF_IDX_W-1:0] rf_addr,
    input  logic [DATA_W-1:0]   rf_rdata,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                done,
    output logic                unpred,
    output logic                wb_en,
    output logic [ADDR_W-1:0]   wb_data
);
    plan_t plan;
    logic  load, step;

    fpst_decode u_decode (
        .insn (insn),
        .base (base),
        .plan (plan)
    );

    fpst_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cond_pass (cond_pass),
        .plan      (plan),
        .mem_ready (mem_ready),
        .load      (load),
        .step      (step),
        .busy      (busy),
        .mem_valid (mem_valid),
        .done      (done),
        .unpred    (unpred),
        .wb_en     (wb_en),
        .wb_data   (wb_data)
    );

    fpst_addr_walk u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .addr0    (plan.addr0),
        .first    (plan.first),
        .step     (step),
        .cur_addr (mem_addr),
        .rf_idx   (rf_addr)
    );

    assign mem_wdata = rf_rdata;

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(rf_addr)); // R9
    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !mem_valid || mem_addr == $past(mem_addr) + ADDR_W'(BYTES_W)); // R3
    AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !mem_valid || rf_addr == $past(rf_addr) + RF_IDX_W'(1)); // R4
    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        done && unpred |-> !$past(mem_valid)); // R7
endmodule

// File: tb/fpst_seq_tb_top.sv
module fpst_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] base = '0;
    logic        cond_pass = 1'b1;
    logic        busy;
    logic [4:0]  rf_addr;
    logic [31:0] rf_rdata;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic        done, unpred, wb_en;
    logic [31:0] wb_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rf_word(input logic [4:0] i);
        return 32'hF000_0000 | (32'(i) << 16) | (32'(i) * 32'd7 + 32'd3);
    endfunction
    assign rf_rdata = rf_word(rf_addr);

    fpst_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .base(base),
        .cond_pass(cond_pass), .busy(busy), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done), .unpred(unpred), .wb_en(wb_en),
        .wb_data(wb_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // expected behaviour from the requirements
    logic [31:0] ex_addr[$];
    logic [4:0]  ex_idx[$];
    bit          ex_unp, ex_wb;
    logic [31:0] ex_wbv;
    string       ex_tag;

    task automatic model(input logic [31:0] ins, input logic [31:0] b, input bit cp);
        bit p = ins[24], u = ins[23], d = ins[22], w = ins[21];
        int fd = int'(ins[15:12]);
        logic [3:0] sel = ins[11:8];
        int off = int'(ins[7:0]);
        logic [31:0] up = b + 32'(off * 4), dn = b - 32'(off * 4);
        bit enc = (ins[27:25] == 3'b110) && !ins[20] && (sel == 4'b1010 || sel == 4'b1011);
        bit bad;
        int first, n;
        logic [31:0] a0;
        ex_addr.delete(); ex_idx.delete();
        ex_wb = 0; ex_wbv = 0;
        if (p && !w) begin
            a0 = u ? up : dn;
            if (sel == 4'b1011) begin first = 2*fd; n = 2; ex_tag = "R2"; end
            else begin first = 2*fd + int'(d); n = 1; ex_tag = "R1"; end
            bad = !enc;
        end else begin
            a0 = u ? b : dn;
            if (sel == 4'b1010) begin
                first = 2*fd + int'(d); n = off; ex_tag = "R3";
                bad = (off == 0) || (first + off > 32);
            end else if (off % 2 == 1) begin
                first = 2*fd; n = off - 1; ex_tag = "R5";
                bad = (off == 1) || (fd + (off-1)/2 > 16);
            end else begin
                first = 2*fd; n = off; ex_tag = "R4";
                bad = (off == 0) || (fd + off/2 > 16);
            end
            bad = bad || !enc;
            ex_wb = cp && !bad && w;
            ex_wbv = u ? up : dn;
        end
        ex_unp = cp && bad;
        if (bad || !cp) n = 0;
        for (int k = 0; k < n; k++) begin
            ex_addr.push_back(a0 + 32'(4*k));
            ex_idx.push_back(5'(first + k));
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [31:0] b, input bit cp,
                       input int ready_pct, input bit poke);
        int k = 0, last = 0, i = 1, nexp;
        bit fin = 0;
        model(ins, b, cp);
        nexp = ex_addr.size();
        @(negedge clk);
        insn = ins; base = b; cond_pass = cp; start = 1'b1;
        @(negedge clk);
        while (!fin) begin
            start = poke ? 1'($urandom % 2) : 1'b0;
            if (poke) begin insn = $urandom; base = $urandom; cond_pass = 1'b1; end
            mem_ready = (($urandom % 100) < ready_pct);
            #1;
            if (mem_valid && mem_ready) begin
                if (k < nexp) begin
                    chk(mem_addr == ex_addr[k], {ex_tag, " addr"}, mem_addr, ex_addr[k]);
                    chk(mem_wdata == rf_word(ex_idx[k]), {ex_tag, " data"}, mem_wdata, rf_word(ex_idx[k]));
                end else chk(0, "R10 extra write", mem_addr, 32'h0);
                k++; last = i;
            end
            if (done) begin
                fin = 1;
                chk(k == nexp, "R8 write count", 32'(k), 32'(nexp));
                chk(i == last + 1, "R9 done timing", 32'(i), 32'(last + 1));
                chk(unpred == ex_unp, "R7 unpred", 32'(unpred), 32'(ex_unp));
                chk(wb_en == ex_wb, "R6 wb_en", 32'(wb_en), 32'(ex_wb));
                if (ex_wb) chk(wb_data == ex_wbv, "R6 wb_data", wb_data, ex_wbv);
            end
            if (i > 400) begin
                fin = 1;
                chk(0, "R9 no done", 32'(i), 32'(last + 1));
            end
            i++;
            @(negedge clk);
        end
        start = 1'b0; mem_ready = 1'b0;
        #1;
        chk(!busy && !mem_valid, "R10 idle after done", {30'b0, busy, mem_valid}, 32'h0);
    endtask

    function automatic logic [31:0] mk(input bit p, input bit u, input bit d, input bit w,
                                       input logic [3:0] fd, input logic [3:0] sel, input logic [7:0] off);
        return {4'hE, 3'b110, p, u, d, w, 1'b0, 4'h5, fd, sel, off};
    endfunction

    function automatic logic [31:0] rnd_insn();
        int kind = $urandom % 5, mode = $urandom % 3;
        logic [3:0] fd = 4'($urandom);
        bit d = 1'($urandom), u = 1'($urandom);
        bit p, w;
        int off;
        if (kind < 2) return mk(1, u, d, 0, fd, kind == 0 ? 4'b1010 : 4'b1011, 8'($urandom));
        p = (mode == 2); w = (mode != 0); u = (mode != 2);
        if (kind == 2) off = ($urandom % 8 == 0) ? int'($urandom % 40) : 1 + int'($urandom % (32 - (2*fd + d)));
        else begin
            off = 2 * (1 + int'($urandom % (16 - fd)));
            if ($urandom % 8 == 0) off = int'($urandom % 40) & ~1;
            if (kind == 4) off = off + 1;
        end
        return mk(p, u, d, w, fd, kind == 2 ? 4'b1010 : 4'b1011, 8'(off));
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        #1;
        chk(!busy && !mem_valid && !done && !unpred && !wb_en, "R11 reset",
            {27'b0, busy, mem_valid, done, unpred, wb_en}, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!busy && !mem_valid && !done, "R11 after reset", {29'b0, busy, mem_valid, done}, 32'h0);
        // directed corners
        run(mk(1, 1, 1, 0, 4'd3, 4'b1010, 8'd5), 32'h1000, 1, 100, 0);   // R1 up
        run(mk(1, 0, 0, 0, 4'd3, 4'b1010, 8'd5), 32'h1000, 1, 100, 0);   // R1 down
        run(mk(1, 1, 0, 0, 4'd15, 4'b1011, 8'd0), 32'h2000, 1, 50, 0);   // R2
        run(mk(0, 1, 0, 1, 4'd2, 4'b1011, 8'd6), 32'h3000, 1, 100, 0);   // R4 D2..D4
        run(mk(1, 0, 0, 1, 4'd2, 4'b1011, 8'd6), 32'h3000, 1, 40, 0);    // R4 decrement, R6
        run(mk(0, 1, 1, 0, 4'd15, 4'b1010, 8'd1), 32'h4000, 1, 100, 0);  // R3 S31 alone
        run(mk(0, 1, 1, 1, 4'd15, 4'b1010, 8'd2), 32'h4000, 1, 100, 0);  // R7 past S31
        run(mk(0, 1, 0, 1, 4'd15, 4'b1011, 8'd2), 32'h5000, 1, 100, 0);  // R4 D15 alone
        run(mk(0, 1, 0, 1, 4'd15, 4'b1011, 8'd4), 32'h5000, 1, 100, 0);  // R7 past D15
        run(mk(0, 1, 0, 1, 4'd15, 4'b1011, 8'd3), 32'h5000, 1, 100, 0);  // R5 two words
        run(mk(0, 1, 0, 1, 4'd0, 4'b1011, 8'd1), 32'h5000, 1, 100, 0);   // R7 odd offset 1
        run(mk(0, 1, 0, 1, 4'd0, 4'b1010, 8'd0), 32'h5000, 1, 100, 0);   // R7 empty list
        run(mk(0, 1, 0, 1, 4'd0, 4'b1001, 8'd4), 32'h5000, 1, 100, 0);   // R7 bad selector
        run(mk(0, 1, 0, 1, 4'd1, 4'b1011, 8'd4), 32'h0, 0, 100, 0);      // R8 condition false
        run(mk(0, 0, 0, 1, 4'd1, 4'b1010, 8'd4), 32'h8, 1, 30, 1);       // R10 poke while busy
        for (int t = 0; t < 300; t++)
            run(rnd_insn(), {$urandom} & 32'hFFFF_FFFC, ($urandom % 8) != 0,
                20 + int'($urandom % 81), ($urandom % 3) == 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        chk(0, "R9 watchdog", 32'(cyc), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule